// File: doc/BRIEF.md
# Iterative Carry-Less Multiplier

This unit multiplies two 32-bit words as polynomials over GF(2). Partial products are combined with XOR, so no carries propagate between columns. A controller starts a job with a one-cycle `start` request and supplies a 3-bit function code. The unit then steps through one multiplier bit per clock. After 32 steps it raises `done` for a single cycle. The 64-bit product is accumulated internally, and the requested 32-bit view of it appears on `result`.

Three views exist:
- **Low view:** the lower word of the product.
- **High view:** the upper word of the product.
- **Reversed view:** both operands are bit-reversed before multiplying, the low word of that product is taken, and that word is bit-reversed again.

The reversed view is built from the operands, not read directly out of the normal product.

Instruction decode and register-file access sit outside the unit. The surrounding pipeline stalls on `busy` and captures `result` when `done` is seen.

Top module: `clmul_iter`

## Requirements
- R1: With function code 3'b001, `result` at `done` equals bits 31:0 of the carry-less product of `op_a` and `op_b`.
- R2: With function code 3'b011, `result` at `done` equals bits 63:32 of the carry-less product.
- R3: With function code 3'b010, `result` at `done` equals the bit-reversed low word of the product of the bit-reversed operands, which is identical to bits 62:31 of the ordinary product.
- R4: Any function code other than 3'b001, 3'b011 and 3'b010 gives a `result` of zero at `done`.
- R5: A `start` seen while idle captures `op_a`, `op_b` and `funct3`, and `busy` is high in the following cycle.
- R6: `done` is high for exactly one cycle. That cycle comes 32 rising edges after the edge that accepted `start`. `busy` is low in that cycle.
- R7: While `busy` is high, `start` and any change on `op_a`, `op_b` or `funct3` have no effect on the running job or its timing.
- R8: After `done`, `result` holds its value until the next accepted `start`, whatever the operand and function-code inputs do.
- R9: A synchronous active-high `rst`, even in the middle of a job, leaves `busy` and `done` low and `result` zero at the next cycle.
- R10: A `start` given in the same cycle that `done` is high is accepted, so jobs can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a new job; honoured only while idle |
| funct3 | input | 3 | View select: 001 low, 011 high, 010 reversed |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle pulse, result valid |
| result | output | 32 | Selected 32-bit view of the product |

## Verification
Two functions can meet in the same cycle:
- **Completion and a new request.** The final step's `done` pulse can coincide with the next job's `start`. The bench issues the second job on the very cycle `done` is seen. It checks that the first result is correct in that cycle, and that the second job is accepted and finishes a full 32 steps later with its own correct value.
- **A running job and a fresh `start`.** A job in progress can collide with a `start` carrying different operands. The bench injects such requests mid-job. It judges them by unchanged completion timing and by the first job's product.

// File: rtl/clmul_pkg.sv
package clmul_pkg;

  localparam int unsigned OP_W = 32;

  typedef enum logic [1:0] {
    VIEW_LOW  = 2'd0,
    VIEW_HIGH = 2'd1,
    VIEW_REV  = 2'd2,
    VIEW_NONE = 2'd3
  } view_e;

  localparam logic [2:0] F3_LOW  = 3'b001;
  localparam logic [2:0] F3_HIGH = 3'b011;
  localparam logic [2:0] F3_REV  = 3'b010;

  function automatic view_e decode_view(input logic [2:0] f3);
    case (f3)
      F3_LOW:  return VIEW_LOW;
      F3_HIGH: return VIEW_HIGH;
      F3_REV:  return VIEW_REV;
      default: return VIEW_NONE;
    endcase
  endfunction

endpackage

// File: rtl/clmul_flip.sv
module clmul_flip #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    assign dout[g] = din[W-1-g];
  end
endmodule

// File: rtl/clmul_ctrl.sv
module clmul_ctrl #(
  parameter int unsigned STEPS = 32,
  localparam int unsigned CW = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          accept,
  output logic          step_en,
  output logic          last_step,
  output logic [CW-1:0] step_cnt,
  output logic          busy,
  output logic          done
);
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  assign accept    = start && !busy;
  assign step_en   = busy;
  assign last_step = busy && (step_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      step_cnt <= '0;
    end else begin
      done <= last_step;
      if (accept) begin
        busy     <= 1'b1;
        step_cnt <= '0;
      end else if (busy) begin
        step_cnt <= step_cnt + 1'b1;
        if (last_step) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/clmul_accum.sv
module clmul_accum #(
  parameter int unsigned W = 32,
  localparam int unsigned PW = 2 * W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [W-1:0]  mcand_in,
  input  logic [W-1:0]  mplier_in,
  output logic [PW-1:0] prod
);
  logic [PW-1:0] mcand_q;
  logic [W-1:0]  mplier_q;

  // One partial-product row: the shifted multiplicand gated by the current multiplier bit.
  function automatic logic [PW-1:0] gf2_row(input logic [PW-1:0] m, input logic sel);
    return sel ? m : '0;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      prod     <= '0;
    end else if (load) begin
      mcand_q  <= {{W{1'b0}}, mcand_in};
      mplier_q <= mplier_in;
      prod     <= '0;
    end else if (step) begin
      prod     <= prod ^ gf2_row(mcand_q, mplier_q[0]);
      mcand_q  <= mcand_q << 1;
      mplier_q <= mplier_q >> 1;
    end
  end
endmodule

// File: rtl/clmul_view.sv
module clmul_view
  import clmul_pkg::*;
#(
  parameter int unsigned W = 32,
  localparam int unsigned PW = 2 * W
) (
  input  view_e         view,
  input  logic [PW-1:0] prod,
  output logic [W-1:0]  result
);
  logic [W-1:0] low_flipped;

  clmul_flip #(.W(W)) u_flip (
    .din  (prod[W-1:0]),
    .dout (low_flipped)
  );

  always_comb begin
    case (view)
      VIEW_LOW:  result = prod[W-1:0];
      VIEW_HIGH: result = prod[PW-1:W];
      VIEW_REV:  result = low_flipped;
      default:   result = '0;
    endcase
  end
endmodule

// File: rtl/clmul_iter.sv
module clmul_iter
  import clmul_pkg::*;
#(
  parameter int unsigned W = OP_W,
  localparam int unsigned PW = 2 * W,
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [2:0]   funct3,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);
  // Named internal events, exposed for the bound checker.
  logic          accept;
  logic          step_en;
  logic          last_step;
  logic [CW-1:0] step_cnt;
  view_e         view_d;
  view_e         view_q;
  logic [W-1:0]  a_flip, b_flip;
  logic [W-1:0]  a_sel, b_sel;
  logic [PW-1:0] prod;

  assign view_d = decode_view(funct3);

  clmul_flip #(.W(W)) u_flip_a (.din(op_a), .dout(a_flip));
  clmul_flip #(.W(W)) u_flip_b (.din(op_b), .dout(b_flip));

  assign a_sel = (view_d == VIEW_REV) ? a_flip : op_a;
  assign b_sel = (view_d == VIEW_REV) ? b_flip : op_b;

  always_ff @(posedge clk) begin
    if (rst)         view_q <= VIEW_LOW;
    else if (accept) view_q <= view_d;
  end

  clmul_ctrl #(.STEPS(W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .accept    (accept),
    .step_en   (step_en),
    .last_step (last_step),
    .step_cnt  (step_cnt),
    .busy      (busy),
    .done      (done)
  );

  clmul_accum #(.W(W)) u_accum (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .step      (step_en),
    .mcand_in  (a_sel),
    .mplier_in (b_sel),
    .prod      (prod)
  );

  clmul_view #(.W(W)) u_view (
    .view   (view_q),
    .prod   (prod),
    .result (result)
  );
endmodule

// File: rtl/clmul_iter_chk.sv
module clmul_iter_chk #(
  parameter int unsigned W = 32,
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          last_step,
  input logic [CW-1:0] step_cnt,
  input logic [W-1:0]  result
);
  // Busy-cycle counter for the completion window (W may be large).
  logic [CW:0] run_len;
  always_ff @(posedge clk) begin
    if (rst)                 run_len <= '0;
    else if (start && !busy) run_len <= '0;
    else if (busy)           run_len <= run_len + 1'b1;
  end

  a_r5_busy_after_start: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r6_done_window: assert property (@(posedge clk) disable iff (rst)
    done |-> (run_len == (CW+1)'(W)));

  a_r7_steps_march: assert property (@(posedge clk) disable iff (rst)
    (busy && !last_step) |=> (busy && step_cnt == CW'($past(step_cnt) + 1'b1)));

  a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(result));

  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (!busy && !done && result == '0));
endmodule

bind clmul_iter clmul_iter_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .last_step (last_step),
  .step_cnt  (step_cnt),
  .result    (result)
);

// File: tb/sim_clmul_iter.sv
module sim_clmul_iter;
  localparam int unsigned W = 32;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst;
  logic         start;
  logic [2:0]   funct3;
  logic [W-1:0] op_a, op_b;
  logic         busy, done;
  logic [W-1:0] result;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clmul_iter #(.W(W)) u0 (
    .clk(clk), .rst(rst), .start(start), .funct3(funct3),
    .op_a(op_a), .op_b(op_b), .busy(busy), .done(done), .result(result)
  );

  // Reference: double sum over bit pairs.
  function automatic logic [2*W-1:0] ref_prod(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [2*W-1:0] p = '0;
    for (int i = 0; i < W; i++)
      for (int j = 0; j < W; j++)
        if (a[i] && b[j]) p[i+j] = ~p[i+j];
    return p;
  endfunction

  function automatic logic [W-1:0] ref_view(input logic [2:0] f3, input logic [W-1:0] a,
                                            input logic [W-1:0] b);
    logic [2*W-1:0] p = ref_prod(a, b);
    case (f3)
      3'b001:  return p[W-1:0];        // R1
      3'b011:  return p[2*W-1:W];      // R2
      3'b010:  return p[2*W-2:W-1];    // R3 identity: bits 62:31
      default: return '0;              // R4
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive a request at the current negedge; return at the next negedge.
  task automatic issue(input logic [2:0] f3, input logic [W-1:0] a, input logic [W-1:0] b);
    start = 1'b1; funct3 = f3; op_a = a; op_b = b;
    @(negedge clk);
    start = 1'b0;
    check("R5 busy after start", W'(busy), W'(1));
    op_a = ~a; op_b = a ^ b; funct3 = ~f3;   // scramble: job must not see these
  endtask

  task automatic wait_done(input string req);
    int edges = 0;
    while (!done && edges < 100) begin
      @(negedge clk);
      edges++;
    end
    check({req, " R6 done after 32 edges"}, W'(edges), W'(32));
  endtask

  task automatic run_one(input logic [2:0] f3, input logic [W-1:0] a, input logic [W-1:0] b,
                         input string req);
    issue(f3, a, b);
    wait_done(req);
    check(req, result, ref_view(f3, a, b));
    @(negedge clk);
    check("R6 done single cycle", W'(done), W'(0));
  endtask

  initial begin
    logic [W-1:0] la, lb, keep;
    rst = 1'b1; start = 1'b0; funct3 = 3'b001; op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    check("R9 reset busy", W'(busy), W'(0));
    check("R9 reset done", W'(done), W'(0));
    check("R9 reset result", result, '0);
    rst = 1'b0;
    @(negedge clk);

    // Directed corner cases
    run_one(3'b001, 32'h0000_0003, 32'h0000_0005, "R1 small");
    run_one(3'b011, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 all ones");
    run_one(3'b010, 32'h8000_0000, 32'h8000_0000, "R3 top bits");
    run_one(3'b001, 32'h0, 32'hDEAD_BEEF, "R1 zero operand");
    run_one(3'b000, 32'h1234_5678, 32'h9ABC_DEF0, "R4 code 000");
    run_one(3'b111, 32'hFFFF_FFFF, 32'h1, "R4 code 111");

    // Sweep: walking one combined with LFSR patterns, all three views
    la = 32'hACE1_1234; lb = 32'h0BAD_F00D;
    for (int i = 0; i < W; i++) begin
      la = {la[30:0], la[31] ^ la[21] ^ la[1] ^ la[0]};
      lb = {lb[30:0], lb[31] ^ lb[21] ^ lb[1] ^ lb[0]};
      run_one(3'b001, la | (32'h1 << i), lb, "R1 sweep");
      run_one(3'b011, la, lb ^ (32'h1 << i), "R2 sweep");
      run_one(3'b010, (32'h1 << i), lb, "R3 sweep");
    end

    // R7: start with other operands while busy
    issue(3'b011, 32'h1357_9BDF, 32'h2468_ACE0);
    repeat (5) @(negedge clk);
    start = 1'b1; funct3 = 3'b001; op_a = 32'hFFFF_FFFF; op_b = 32'hFFFF_FFFF;
    repeat (2) @(negedge clk);
    start = 1'b0;
    begin
      int edges = 7;
      while (!done && edges < 100) begin
        @(negedge clk);
        edges++;
      end
      check("R7 timing unchanged by start while busy", W'(edges), W'(32));
    end
    check("R7 result of first job", result, ref_view(3'b011, 32'h1357_9BDF, 32'h2468_ACE0));

    // R8: hold after done with inputs moving
    keep = result;
    @(negedge clk);
    funct3 = 3'b010; op_a = 32'h5555_AAAA; op_b = 32'h0F0F_F0F0;
    repeat (3) @(negedge clk);
    check("R8 result held while idle", result, keep);
    check("R8 no spurious done", W'(done), W'(0));

    // R10: back-to-back, second start in the done cycle
    issue(3'b001, 32'hCAFE_0001, 32'h0000_8001);
    wait_done("R10 first");
    check("R10 first result", result, ref_view(3'b001, 32'hCAFE_0001, 32'h0000_8001));
    issue(3'b010, 32'h0001_0203, 32'hF00F_0FF0);
    wait_done("R10 second");
    check("R10 second result", result, ref_view(3'b010, 32'h0001_0203, 32'hF00F_0FF0));
    @(negedge clk);

    // R9: reset mid-job
    issue(3'b011, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9 mid-job reset busy", W'(busy), W'(0));
    check("R9 mid-job reset done", W'(done), W'(0));
    check("R9 mid-job reset result", result, '0);
    repeat (40) @(negedge clk);
    check("R9 no done after reset", W'(done), W'(0));

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule